// File: doc/BRIEF.md
# Command-Driven Status and Error Controller

This block keeps a small device status word, a two-bit power state and a sticky error register with one bit per monitored analog node. Host commands arrive already decoded as a valid strobe plus a three-bit code. Entering standby takes two commands: a request first, then a confirmation. A separate wake command brings the device back to active. A test-mode entry signal latches a test flag, and a clear command drops it again. The oscillator-enable level is mirrored into the status word.

Six per-node out-of-range flags are sampled only when the measurement strobe is high. Any flag seen at that moment sets its error bit, and the bit stays set until the host clears it with a write-one-to-clear mask. The critical-error status bit is the OR of the error register, so it cannot be cleared on its own. The error register has a parameterised reset value, which lets it come out of reset with bits already set. Power transitions never touch it.

Top module: `stat_err_ctrl`

## Requirements
- R1: While reset is asserted, powerState is 2'b00 (active), statusFlags is 4'b0000 and errReg equals the ERR_RESET parameter (default all zero).
- R2: A request command (cmdCode 1) with cmdValid in the active state sets statusFlags[3] (standby request) one clock later and leaves powerState unchanged.
- R3: A confirm command (cmdCode 2) while a request is pending moves powerState to 2'b01 (standby) and clears statusFlags[3], one clock later.
- R4: A confirm command with no pending request is ignored: powerState and statusFlags[3] keep their values.
- R5: A wake command (cmdCode 4) in standby returns powerState to 2'b00 with statusFlags[3] low. A wake command in the active state has no effect.
- R6: A high testEntry sets statusFlags[2] (test mode), which stays high until a clear command (cmdCode 3) drops it. When testEntry and a clear command fall on the same cycle, test mode is kept.
- R7: statusFlags[1] equals oscEnable as sampled at the previous clock edge.
- R8: errReg[i] is set one clock after a cycle with measStrobe and monFlags[i] both high. monFlags is ignored while measStrobe is low. A set bit stays set without a host clear. The bit order, from bit 0 up, is: amplifier clipping, DAC/feedback mismatch, reference, ambient/temperature common mode, oscillator frequency, supply.
- R9: statusFlags[0] (critical error) is high exactly when any errReg bit is set, and it falls only after a host clear.
- R10: errClrValid clears exactly those errReg bits whose errClrMask bit is 1 (write-one-to-clear). All other bits are kept.
- R11: When a sampled monitor event and a host clear hit the same bit in the same cycle, the bit ends up set.
- R12: Command codes 0, 5, 6 and 7, and any code while cmdValid is low, change nothing. Standby and wake transitions leave errReg unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Decoded command strobe |
| cmdCode | input | 3 | Command: 1 request standby, 2 confirm standby, 3 clear test mode, 4 wake |
| testEntry | input | 1 | Test-mode entry pulse |
| oscEnable | input | 1 | Internal oscillator enabled level |
| measStrobe | input | 1 | Measurement-cycle sample strobe |
| monFlags | input | NUM_NODES | Per-node out-of-range flags |
| errClrValid | input | 1 | Host error-clear strobe |
| errClrMask | input | NUM_NODES | Write-one-to-clear mask |
| powerState | output | 2 | 00 active, 01 standby |
| statusFlags | output | 4 | bit0 critical error, bit1 oscillator on, bit2 test mode, bit3 standby request |
| errReg | output | NUM_NODES | Sticky per-node error register |

## Verification
The standby handshake is exercised in the legal order (request, confirm, wake) and against the orders it must refuse: a confirm with no request, a wake while active, and unknown or invalid codes. Together these separate a real two-step handshake from a one-step decoder. The error register receives monitor flags with and without the sample strobe, partial and full clear masks, and a same-bit collision of event and clear. These patterns distinguish sticky setting, gating by the strobe, selective clearing and the event-wins priority. Test mode is driven with a single entry, with a later clear, and with entry and clear together, and errors are held across a full standby round trip.

// File: rtl/stat_err_pkg.sv
package stat_err_pkg;

  localparam int CMD_W = 3;
  localparam int PWR_W = 2;
  localparam int STATUS_W = 4;

  localparam logic [CMD_W-1:0] CMD_REQ_STBY  = 3'd1;
  localparam logic [CMD_W-1:0] CMD_CONF_STBY = 3'd2;
  localparam logic [CMD_W-1:0] CMD_CLEAR     = 3'd3;
  localparam logic [CMD_W-1:0] CMD_WAKE      = 3'd4;

  localparam logic [PWR_W-1:0] PWR_ACTIVE  = 2'b00;
  localparam logic [PWR_W-1:0] PWR_STANDBY = 2'b01;

  localparam int ST_CRIT = 0;
  localparam int ST_OSC  = 1;
  localparam int ST_TEST = 2;
  localparam int ST_REQ  = 3;

  typedef struct packed {
    logic setReq;
    logic clrReq;
    logic goStandby;
    logic goActive;
    logic enterTest;
    logic exitTest;
  } ctrl_strobe_t;

endpackage

// File: rtl/stat_err_cmd.sv
module stat_err_cmd
  import stat_err_pkg::*;
(
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdCode,
  input  logic             testEntry,
  input  logic             inStandby,
  input  logic             reqPending,
  output ctrl_strobe_t     strb
);

  always_comb begin
    strb = '0;
    if (cmdValid) begin
      case (cmdCode)
        CMD_REQ_STBY: begin
          if (!inStandby) strb.setReq = 1'b1;
        end
        CMD_CONF_STBY: begin
          if (!inStandby && reqPending) begin
            strb.goStandby = 1'b1;
            strb.clrReq    = 1'b1;
          end
        end
        CMD_WAKE: begin
          if (inStandby) begin
            strb.goActive = 1'b1;
            strb.clrReq   = 1'b1;
          end
        end
        CMD_CLEAR: strb.exitTest = 1'b1;
        default: ;
      endcase
    end
    if (testEntry) strb.enterTest = 1'b1;
  end

endmodule

// File: rtl/stat_err_dp.sv
module stat_err_dp
  import stat_err_pkg::*;
#(
  parameter int NUM_NODES = 6,
  parameter logic [NUM_NODES-1:0] ERR_RESET = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobe_t         strb,
  input  logic                 oscEnable,
  input  logic                 measStrobe,
  input  logic [NUM_NODES-1:0] monFlags,
  input  logic                 errClrValid,
  input  logic [NUM_NODES-1:0] errClrMask,
  output logic                 inStandby,
  output logic                 reqPending,
  output logic [PWR_W-1:0]     powerState,
  output logic [STATUS_W-1:0]  statusFlags,
  output logic [NUM_NODES-1:0] errReg
);

  logic [PWR_W-1:0]     pwrQ;
  logic                 reqQ;
  logic                 testQ;
  logic                 oscQ;
  logic [NUM_NODES-1:0] errQ;
  logic [NUM_NODES-1:0] errNext;

  // Per-node sticky cell: a sampled event has priority over a host clear.
  for (genvar i = 0; i < NUM_NODES; i++) begin : g_node
    assign errNext[i] = (measStrobe && monFlags[i]) ? 1'b1 :
                        (errClrValid && errClrMask[i]) ? 1'b0 : errQ[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrQ  <= PWR_ACTIVE;
      reqQ  <= 1'b0;
      testQ <= 1'b0;
      oscQ  <= 1'b0;
      errQ  <= ERR_RESET;
    end else begin
      if (strb.goStandby)     pwrQ <= PWR_STANDBY;
      else if (strb.goActive) pwrQ <= PWR_ACTIVE;

      if (strb.setReq)      reqQ <= 1'b1;
      else if (strb.clrReq) reqQ <= 1'b0;

      if (strb.enterTest)     testQ <= 1'b1;
      else if (strb.exitTest) testQ <= 1'b0;

      oscQ <= oscEnable;
      errQ <= errNext;
    end
  end

  assign inStandby  = (pwrQ == PWR_STANDBY);
  assign reqPending = reqQ;
  assign powerState = pwrQ;
  assign errReg     = errQ;

  always_comb begin
    statusFlags          = '0;
    statusFlags[ST_CRIT] = |errQ;
    statusFlags[ST_OSC]  = oscQ;
    statusFlags[ST_TEST] = testQ;
    statusFlags[ST_REQ]  = reqQ;
  end

endmodule

// File: rtl/stat_err_ctrl.sv
module stat_err_ctrl
  import stat_err_pkg::*;
#(
  parameter int NUM_NODES = 6,
  parameter logic [NUM_NODES-1:0] ERR_RESET = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdCode,
  input  logic                 testEntry,
  input  logic                 oscEnable,
  input  logic                 measStrobe,
  input  logic [NUM_NODES-1:0] monFlags,
  input  logic                 errClrValid,
  input  logic [NUM_NODES-1:0] errClrMask,
  output logic [1:0]           powerState,
  output logic [3:0]           statusFlags,
  output logic [NUM_NODES-1:0] errReg
);

  ctrl_strobe_t strb;
  logic         inStandby;
  logic         reqPending;

  stat_err_cmd u_cmd (
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .testEntry  (testEntry),
    .inStandby  (inStandby),
    .reqPending (reqPending),
    .strb       (strb)
  );

  stat_err_dp #(
    .NUM_NODES (NUM_NODES),
    .ERR_RESET (ERR_RESET)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .oscEnable   (oscEnable),
    .measStrobe  (measStrobe),
    .monFlags    (monFlags),
    .errClrValid (errClrValid),
    .errClrMask  (errClrMask),
    .inStandby   (inStandby),
    .reqPending  (reqPending),
    .powerState  (powerState),
    .statusFlags (statusFlags),
    .errReg      (errReg)
  );

endmodule

// File: rtl/stat_err_chk.sv
module stat_err_chk
  import stat_err_pkg::*;
#(
  parameter int NUM_NODES = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cmdValid,
  input logic [2:0]           cmdCode,
  input logic                 testEntry,
  input logic                 oscEnable,
  input logic                 measStrobe,
  input logic [NUM_NODES-1:0] monFlags,
  input logic                 errClrValid,
  input logic [NUM_NODES-1:0] errClrMask,
  input logic [1:0]           powerState,
  input logic [3:0]           statusFlags,
  input logic [NUM_NODES-1:0] errReg
);

  p_req_holds_power_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == CMD_REQ_STBY && powerState == PWR_ACTIVE)
    |=> (statusFlags[ST_REQ] && $stable(powerState)));

  p_confirm_enters_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == CMD_CONF_STBY && statusFlags[ST_REQ] && powerState == PWR_ACTIVE)
    |=> (powerState == PWR_STANDBY && !statusFlags[ST_REQ]));

  p_confirm_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == CMD_CONF_STBY && !statusFlags[ST_REQ])
    |=> ($stable(powerState) && !statusFlags[ST_REQ]));

  p_wake_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == CMD_WAKE && powerState == PWR_STANDBY)
    |=> (powerState == PWR_ACTIVE && !statusFlags[ST_REQ]));

  p_test_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statusFlags[ST_TEST] && !(cmdValid && cmdCode == CMD_CLEAR))
    |=> statusFlags[ST_TEST]);

  p_osc_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (statusFlags[ST_OSC] == $past(oscEnable)));

  p_err_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    measStrobe |=> ((errReg & $past(monFlags)) == $past(monFlags)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    !errClrValid |=> ((errReg & $past(errReg)) == $past(errReg)));

  p_crit_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusFlags[ST_CRIT]) |-> $past(errClrValid));

  p_w1c_r10: assert property (@(posedge clk) disable iff (!rstN)
    (errClrValid && !measStrobe) |=> ((errReg & $past(errClrMask)) == '0));

  p_w1c_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    errClrValid |=> ((errReg & ~$past(errClrMask) & $past(errReg)) == ($past(errReg) & ~$past(errClrMask))));

  p_stby_err_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!measStrobe && !errClrValid) |=> $stable(errReg));

endmodule

bind stat_err_ctrl stat_err_chk #(.NUM_NODES(NUM_NODES)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdCode     (cmdCode),
  .testEntry   (testEntry),
  .oscEnable   (oscEnable),
  .measStrobe  (measStrobe),
  .monFlags    (monFlags),
  .errClrValid (errClrValid),
  .errClrMask  (errClrMask),
  .powerState  (powerState),
  .statusFlags (statusFlags),
  .errReg      (errReg)
);

// File: tb/stat_err_ctrl_bench.sv
module stat_err_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NODES = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cmdValid = 1'b0;
  logic [2:0]       cmdCode = 3'd0;
  logic             testEntry = 1'b0;
  logic             oscEnable = 1'b0;
  logic             measStrobe = 1'b0;
  logic [NODES-1:0] monFlags = '0;
  logic             errClrValid = 1'b0;
  logic [NODES-1:0] errClrMask = '0;
  logic [1:0]       powerState;
  logic [3:0]       statusFlags;
  logic [NODES-1:0] errReg;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stat_err_ctrl #(.NUM_NODES(NODES)) u_stat_err_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .testEntry(testEntry), .oscEnable(oscEnable), .measStrobe(measStrobe),
    .monFlags(monFlags), .errClrValid(errClrValid), .errClrMask(errClrMask),
    .powerState(powerState), .statusFlags(statusFlags), .errReg(errReg)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive a command for one cycle; result is visible at the following negedge.
  task automatic issue(input logic [2:0] code, input logic valid);
    @(negedge clk);
    cmdValid = valid;
    cmdCode  = code;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdCode  = 3'd0;
  endtask

  task automatic sample(input logic [NODES-1:0] flags, input logic strobe,
                        input logic clrV, input logic [NODES-1:0] mask);
    @(negedge clk);
    monFlags    = flags;
    measStrobe  = strobe;
    errClrValid = clrV;
    errClrMask  = mask;
    @(negedge clk);
    monFlags    = '0;
    measStrobe  = 1'b0;
    errClrValid = 1'b0;
    errClrMask  = '0;
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    check("R1", "power in reset", 32'(powerState), 32'h0);
    check("R1", "flags in reset", 32'(statusFlags), 32'h0);
    check("R1", "err in reset", 32'(errReg), 32'h0);
    rstN = 1'b1;
  endtask

  task automatic t_handshake();
    issue(3'd1, 1'b1);
    check("R2", "req flag set", 32'(statusFlags[3]), 32'h1);
    check("R2", "power unchanged", 32'(powerState), 32'h0);
    issue(3'd2, 1'b1);
    check("R3", "power standby", 32'(powerState), 32'h1);
    check("R3", "req flag cleared", 32'(statusFlags[3]), 32'h0);
    check("R12", "err kept in standby", 32'(errReg), 32'h0);
  endtask

  task automatic t_wake();
    issue(3'd4, 1'b1);
    check("R5", "wake to active", 32'(powerState), 32'h0);
    check("R5", "req low after wake", 32'(statusFlags[3]), 32'h0);
    issue(3'd4, 1'b1);
    check("R5", "wake in active ignored", 32'(powerState), 32'h0);
  endtask

  task automatic t_confirm_no_req();
    issue(3'd2, 1'b1);
    check("R4", "confirm without req power", 32'(powerState), 32'h0);
    check("R4", "confirm without req flag", 32'(statusFlags[3]), 32'h0);
  endtask

  task automatic t_ignored_codes();
    issue(3'd1, 1'b0);
    check("R12", "invalid strobe ignored", 32'(statusFlags), 32'h0);
    issue(3'd5, 1'b1);
    issue(3'd0, 1'b1);
    issue(3'd7, 1'b1);
    check("R12", "unknown codes flags", 32'(statusFlags), 32'h0);
    check("R12", "unknown codes power", 32'(powerState), 32'h0);
  endtask

  task automatic t_test_mode();
    @(negedge clk); testEntry = 1'b1;
    @(negedge clk); testEntry = 1'b0;
    check("R6", "test set", 32'(statusFlags[2]), 32'h1);
    repeat (3) @(negedge clk);
    check("R6", "test held", 32'(statusFlags[2]), 32'h1);
    issue(3'd3, 1'b1);
    check("R6", "test cleared", 32'(statusFlags[2]), 32'h0);
    @(negedge clk); testEntry = 1'b1; cmdValid = 1'b1; cmdCode = 3'd3;
    @(negedge clk); testEntry = 1'b0; cmdValid = 1'b0; cmdCode = 3'd0;
    check("R6", "entry beats clear", 32'(statusFlags[2]), 32'h1);
    issue(3'd3, 1'b1);
    check("R6", "test cleared again", 32'(statusFlags[2]), 32'h0);
  endtask

  task automatic t_osc();
    @(negedge clk); oscEnable = 1'b1;
    @(negedge clk);
    check("R7", "osc on", 32'(statusFlags[1]), 32'h1);
    oscEnable = 1'b0;
    @(negedge clk);
    check("R7", "osc off", 32'(statusFlags[1]), 32'h0);
  endtask

  task automatic t_errors();
    sample(6'b000101, 1'b0, 1'b0, '0);
    check("R8", "flags without strobe ignored", 32'(errReg), 32'h0);
    check("R9", "crit low", 32'(statusFlags[0]), 32'h0);
    sample(6'b000101, 1'b1, 1'b0, '0);
    check("R8", "sampled bits set", 32'(errReg), 32'h05);
    check("R9", "crit high", 32'(statusFlags[0]), 32'h1);
    repeat (4) @(negedge clk);
    check("R8", "bits sticky", 32'(errReg), 32'h05);
    sample('0, 1'b0, 1'b1, 6'b000001);
    check("R10", "partial clear", 32'(errReg), 32'h04);
    check("R9", "crit stays", 32'(statusFlags[0]), 32'h1);
    sample('0, 1'b0, 1'b1, 6'b000100);
    check("R10", "full clear", 32'(errReg), 32'h0);
    check("R9", "crit falls after clear", 32'(statusFlags[0]), 32'h0);
  endtask

  task automatic t_collision();
    sample(6'b100000, 1'b1, 1'b0, '0);
    sample(6'b100000, 1'b1, 1'b1, 6'b100001);
    check("R11", "event wins over clear", 32'(errReg), 32'h20);
    sample(6'b000010, 1'b1, 1'b1, 6'b100000);
    check("R11", "other bit clears while new sets", 32'(errReg), 32'h02);
    sample('0, 1'b0, 1'b1, 6'b111111);
    check("R10", "clear all", 32'(errReg), 32'h0);
  endtask

  task automatic t_standby_errors();
    sample(6'b010000, 1'b1, 1'b0, '0);
    issue(3'd1, 1'b1);
    issue(3'd2, 1'b1);
    check("R12", "err across standby", 32'(errReg), 32'h10);
    check("R3", "standby again", 32'(powerState), 32'h1);
    issue(3'd4, 1'b1);
    check("R12", "err across wake", 32'(errReg), 32'h10);
    check("R9", "crit after wake", 32'(statusFlags[0]), 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_handshake();
    t_wake();
    t_confirm_no_req();
    t_ignored_codes();
    t_test_mode();
    t_osc();
    t_errors();
    t_collision();
    t_standby_errors();
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule